// File: doc/BRIEF.md
# SPI Flash Command Cycle Engine

This block runs one serial flash command cycle at a time on a single-lane SPI port. Software sets up the cycle through a small register port. It loads a table of eight one-byte opcodes, each with a two-bit cycle type. It writes a 24-bit flash address and, for write cycles, up to `BUF_BYTES` bytes into a data buffer. It then writes a control word that names a table entry and sets the go bit. The engine drives chip select, the serial clock and MOSI, and samples MISO. When the cycle is over it raises a done flag in the status register, which software polls.

A cycle can be preceded by a prefix frame, such as a write-enable opcode. The prefix frame has its own chip-select period, and the engine chains it to the main frame without software involvement. After a lock bit is set, the opcode table, the type table and the prefix register can no longer be changed. The serial clock is divided from the system clock, and a control bit chooses a fast or a slow rate.

Inside the block, the phase sequencer hands bytes to the bit serializer over a valid/ready pair. The sequencer holds `tx_valid` and the byte steady until the serializer accepts it. The serializer accepts a new byte only after it has reported the previous one. The register port is a plain write strobe with a combinational read, with no back-pressure.

Top module: `spi_cycle_engine`

Register words (`reg_addr`): 0 control, 1 status, 2 address, 3 opcodes 0-3, 4 opcodes 4-7, 5 types, 6 prefix, 7 lock. Words 16 to 31 hold the data buffer.

## Requirements
- R1: After reset, the status word reads 0, `spi_cs_n` is 1, `spi_sclk` is 0, and the opcode, type and prefix registers read 0.
- R2: The opcode sent first in the main frame is table entry k, where k is control bits [6:4]. Entry k sits in byte k%4 of word 3 (k<4) or word 4 (k>=4). The cycle type of entry k is types[2k+1:2k]: 0 is read without address, 1 is write without address, 2 is read with address, 3 is write with address.
- R3: For types 2 and 3, the three bytes of address[23:0] follow the opcode, most significant byte first. Types 0 and 1 send no address.
- R4: For a write type with data enable (control bit 2), the frame carries control[13:8]+1 bytes taken from the buffer. Byte j of the buffer is bits [8*(j%4)+7 : 8*(j%4)] of word 16+j/4.
- R5: For a read type with data enable, control[13:8]+1 bytes are clocked in from MISO, most significant bit first. They are stored at buffer positions 0 to n-1, and the buffer bytes at positions n and above keep their values.
- R6: With control bit 1 set, the byte in the prefix register (word 6) is sent as a one-byte frame of its own. Chip select then stays high for at least two serial clock periods before the main frame begins.
- R7: SPI mode 0. MOSI changes only while SCLK is low, and SCLK stays low while chip select is high. When control bit 3 is 1, each SCLK half period lasts `FAST_HALF` system clocks; otherwise it lasts `SLOW_HALF` system clocks.
- R8: Status bit 0 is busy, bit 1 is done and bit 2 is error. Done is set when a cycle ends. Writing a 1 to bit 1 clears done, and writing a 1 to bit 2 clears error.
- R9: A control write with the go bit set while a cycle is in progress does not start a cycle and does not change the cycle in flight, and it sets the error flag.
- R10: Writing 1 to lock bit 0 (word 7) freezes the opcode table, the type table and the prefix register until reset. Cycles still run afterwards.
- R11: With data enable clear, the main frame ends after the opcode, or after the address for types 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The bench builds the engine with its defaults: a 64-byte buffer, a fast half period of one system clock and a slow half period of two. With these values, a sweep over all eight table entries at both clock rates covers every cycle type, prefix frames both on and off, and data enable both set and clear. It also includes a full 64-byte transfer at the buffer boundary. For each cycle the bench checks the complete buffer, the chip-select gap and the SCLK high time against values it computes itself.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_GAP, ST_OPC, ST_ADR, ST_DAT
  } seq_state_e;

  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_STAT = 3'd1;
  localparam logic [2:0] RA_ADDR = 3'd2;
  localparam logic [2:0] RA_MENA = 3'd3;
  localparam logic [2:0] RA_MENB = 3'd4;
  localparam logic [2:0] RA_TYPE = 3'd5;
  localparam logic [2:0] RA_PREF = 3'd6;
  localparam logic [2:0] RA_LOCK = 3'd7;
endpackage

// File: rtl/spi_eng_shift.sv
module spi_eng_shift #(
  parameter int HW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] half_m1,
  input  logic          tx_valid,
  output logic          tx_ready,
  input  logic [7:0]    tx_byte,
  output logic          rx_valid,
  output logic [7:0]    rx_byte,
  output logic          sclk,
  output logic          mosi,
  input  logic          miso
);
  logic          active, phase, done_q;
  logic [HW-1:0] hcnt;
  logic [2:0]    bitcnt;
  logic [7:0]    sh, rx;

  assign tx_ready = !active && !done_q;
  assign rx_valid = done_q;
  assign rx_byte  = rx;
  assign sclk     = active && phase;
  assign mosi     = sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; phase <= 1'b0; done_q <= 1'b0;
      hcnt <= '0; bitcnt <= '0; sh <= '0; rx <= '0;
    end else begin
      done_q <= 1'b0;
      if (!active) begin
        if (tx_valid && tx_ready) begin
          active <= 1'b1; sh <= tx_byte; phase <= 1'b0;
          hcnt <= '0; bitcnt <= '0;
        end
      end else if (hcnt == half_m1) begin
        hcnt  <= '0;
        phase <= ~phase;
        if (!phase) begin
          rx <= {rx[6:0], miso};          // rising edge: sample
        end else begin
          sh     <= {sh[6:0], 1'b0};      // falling edge: next bit
          bitcnt <= bitcnt + 3'd1;
          if (bitcnt == 3'd7) begin
            active <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end

  // R7: MOSI holds while SCLK is high
  a_r7_mosi_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));
endmodule

// File: rtl/spi_eng_seq.sv
module spi_eng_seq
  import spi_eng_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int HW    = 2,
  parameter int GW    = HW + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             pre_en,
  input  logic             dat_en,
  input  logic [2:0]       idx,
  input  logic [CNT_W-1:0] cnt_m1,
  input  logic [23:0]      addr,
  input  logic [63:0]      menu_flat,
  input  logic [15:0]      types,
  input  logic [7:0]       prefix,
  input  logic [HW-1:0]    half_m1,
  output logic [CNT_W-1:0] br_idx,
  input  logic [7:0]       br_byte,
  output logic             bw_en,
  output logic [CNT_W-1:0] bw_idx,
  output logic [7:0]       bw_byte,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [7:0]       tx_byte,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  output logic             cs_n,
  output logic             busy,
  output logic             done_pulse
);
  seq_state_e       st;
  logic [7:0]       opc_q;
  logic [1:0]       typ_q;
  logic [CNT_W-1:0] cnt_q;
  logic [GW-1:0]    gcnt;
  logic [GW-1:0]    gap_last;

  assign gap_last = {half_m1, 2'b11};   // 4 half periods minus one
  assign busy     = (st != ST_IDLE);
  assign tx_valid = (st == ST_PRE) || (st == ST_OPC) || (st == ST_ADR) || (st == ST_DAT);
  assign cs_n     = !tx_valid;
  assign br_idx   = cnt_q;
  assign bw_en    = (st == ST_DAT) && rx_valid && !typ_q[0];
  assign bw_idx   = cnt_q;
  assign bw_byte  = rx_byte;

  always_comb begin
    unique case (st)
      ST_PRE: tx_byte = prefix;
      ST_OPC: tx_byte = opc_q;
      ST_ADR: case (cnt_q[1:0])
                2'd0:    tx_byte = addr[23:16];
                2'd1:    tx_byte = addr[15:8];
                default: tx_byte = addr[7:0];
              endcase
      ST_DAT: tx_byte = typ_q[0] ? br_byte : 8'h00;
      default: tx_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; opc_q <= '0; typ_q <= '0; cnt_q <= '0; gcnt <= '0;
      done_pulse <= 1'b0;
    end else begin
      done_pulse <= 1'b0;
      unique case (st)
        ST_IDLE: if (go) begin
          opc_q <= menu_flat[{idx, 3'b000} +: 8];
          typ_q <= types[{idx, 1'b0} +: 2];
          cnt_q <= '0;
          st    <= pre_en ? ST_PRE : ST_OPC;
        end
        ST_PRE: if (rx_valid) begin
          gcnt <= '0; st <= ST_GAP;
        end
        ST_GAP: if (gcnt == gap_last) st <= ST_OPC;
                else gcnt <= gcnt + 1'b1;
        ST_OPC: if (rx_valid) begin
          cnt_q <= '0;
          if (typ_q[1])    st <= ST_ADR;
          else if (dat_en) st <= ST_DAT;
          else begin st <= ST_IDLE; done_pulse <= 1'b1; end
        end
        ST_ADR: if (rx_valid) begin
          if (cnt_q == CNT_W'(2)) begin
            cnt_q <= '0;
            if (dat_en) st <= ST_DAT;
            else begin st <= ST_IDLE; done_pulse <= 1'b1; end
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_DAT: if (rx_valid) begin
          if (cnt_q == cnt_m1) begin st <= ST_IDLE; done_pulse <= 1'b1; end
          else cnt_q <= cnt_q + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R4: an offered byte stays offered until the serializer takes it
  a_r4_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !rx_valid) |=> tx_valid);
endmodule

// File: rtl/spi_eng_regs.sv
module spi_eng_regs
  import spi_eng_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int AW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             seq_busy,
  input  logic             done_set,
  input  logic             bw_en,
  input  logic [CNT_W-1:0] bw_idx,
  input  logic [7:0]       bw_byte,
  input  logic [CNT_W-1:0] br_idx,
  output logic [7:0]       br_byte,
  output logic             go,
  output logic             pre_en,
  output logic             dat_en,
  output logic             fast,
  output logic [2:0]       idx,
  output logic [CNT_W-1:0] cnt_m1,
  output logic [23:0]      addr,
  output logic [63:0]      menu_flat,
  output logic [15:0]      types,
  output logic [7:0]       prefix
);
  localparam int BYTES = 1 << CNT_W;

  logic [7:0] bufm [BYTES];
  logic       lock_q, done_q, err_q, busy_all;
  logic       is_buf, wr_ctrl, wr_stat, go_busy;
  logic [AW-2:0] wsel;

  assign is_buf   = reg_addr[AW-1];
  assign wsel     = reg_addr[AW-2:0];
  assign wr_ctrl  = reg_wr && !is_buf && reg_addr[2:0] == RA_CTRL;
  assign wr_stat  = reg_wr && !is_buf && reg_addr[2:0] == RA_STAT;
  assign busy_all = seq_busy || go;
  assign go_busy  = wr_ctrl && reg_wdata[0] && busy_all;
  assign br_byte  = bufm[br_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go <= 1'b0; pre_en <= 1'b0; dat_en <= 1'b0; fast <= 1'b0; idx <= '0;
      cnt_m1 <= '0; addr <= '0; menu_flat <= '0; types <= '0; prefix <= '0;
      lock_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0;
    end else begin
      go <= 1'b0;
      if (done_set) done_q <= 1'b1;
      else if (wr_stat && reg_wdata[1]) done_q <= 1'b0;
      if (go_busy) err_q <= 1'b1;
      else if (wr_stat && reg_wdata[2]) err_q <= 1'b0;
      if (wr_ctrl && !busy_all) begin
        go <= reg_wdata[0]; pre_en <= reg_wdata[1]; dat_en <= reg_wdata[2];
        fast <= reg_wdata[3]; idx <= reg_wdata[6:4]; cnt_m1 <= reg_wdata[8 +: CNT_W];
      end
      if (reg_wr && !is_buf) begin
        unique case (reg_addr[2:0])
          RA_ADDR: addr <= reg_wdata[23:0];
          RA_MENA: if (!lock_q) menu_flat[31:0]  <= reg_wdata;
          RA_MENB: if (!lock_q) menu_flat[63:32] <= reg_wdata;
          RA_TYPE: if (!lock_q) types  <= reg_wdata[15:0];
          RA_PREF: if (!lock_q) prefix <= reg_wdata[7:0];
          RA_LOCK: if (reg_wdata[0]) lock_q <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (reg_wr && is_buf)
      for (int k = 0; k < 4; k++) bufm[{wsel, 2'(k)}] <= reg_wdata[8*k +: 8];
    if (bw_en) bufm[bw_idx] <= bw_byte;
  end

  always_comb begin
    reg_rdata = '0;
    if (is_buf) begin
      for (int k = 0; k < 4; k++) reg_rdata[8*k +: 8] = bufm[{wsel, 2'(k)}];
    end else begin
      unique case (reg_addr[2:0])
        RA_CTRL: reg_rdata = 32'({cnt_m1, 1'b0, idx, fast, dat_en, pre_en, 1'b0});
        RA_STAT: reg_rdata = {29'd0, err_q, done_q, busy_all};
        RA_ADDR: reg_rdata = {8'd0, addr};
        RA_MENA: reg_rdata = menu_flat[31:0];
        RA_MENB: reg_rdata = menu_flat[63:32];
        RA_TYPE: reg_rdata = {16'd0, types};
        RA_PREF: reg_rdata = {24'd0, prefix};
        default: reg_rdata = {31'd0, lock_q};
      endcase
    end
  end

  // R8: done rises only right after the sequencer was running
  a_r8_done_after_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(seq_busy, 2));
  // R9: a launch reaches the sequencer only while it is idle
  a_r9_go_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !seq_busy);
  // R10: locked configuration never moves
  a_r10_lock_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> ($stable(menu_flat) && $stable(types) && $stable(prefix)));
endmodule

// File: rtl/spi_cycle_engine.sv
module spi_cycle_engine #(
  parameter int BUF_BYTES = 64,
  parameter int FAST_HALF = 1,
  parameter int SLOW_HALF = 2,
  localparam int CNT_W    = $clog2(BUF_BYTES),
  localparam int AW       = CNT_W - 1,
  localparam int HW       = $clog2(SLOW_HALF) + 1,
  localparam int GW       = HW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          spi_cs_n,
  output logic          spi_sclk,
  output logic          spi_mosi,
  input  logic          spi_miso
);
  logic             go, pre_en, dat_en, fast, seq_busy, done_pulse;
  logic [2:0]       idx;
  logic [CNT_W-1:0] cnt_m1, br_idx, bw_idx;
  logic [23:0]      addr;
  logic [63:0]      menu_flat;
  logic [15:0]      types;
  logic [7:0]       prefix, br_byte, bw_byte, tx_byte, rx_byte;
  logic             bw_en, tx_valid, tx_ready, rx_valid;
  logic [HW-1:0]    half_m1;

  assign half_m1 = fast ? HW'(FAST_HALF - 1) : HW'(SLOW_HALF - 1);

  spi_eng_regs #(.CNT_W(CNT_W), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .seq_busy(seq_busy),
    .done_set(done_pulse), .bw_en(bw_en), .bw_idx(bw_idx), .bw_byte(bw_byte),
    .br_idx(br_idx), .br_byte(br_byte), .go(go), .pre_en(pre_en),
    .dat_en(dat_en), .fast(fast), .idx(idx), .cnt_m1(cnt_m1), .addr(addr),
    .menu_flat(menu_flat), .types(types), .prefix(prefix));

  spi_eng_seq #(.CNT_W(CNT_W), .HW(HW), .GW(GW)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .pre_en(pre_en), .dat_en(dat_en),
    .idx(idx), .cnt_m1(cnt_m1), .addr(addr), .menu_flat(menu_flat),
    .types(types), .prefix(prefix), .half_m1(half_m1), .br_idx(br_idx),
    .br_byte(br_byte), .bw_en(bw_en), .bw_idx(bw_idx), .bw_byte(bw_byte),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_byte(tx_byte),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .cs_n(spi_cs_n),
    .busy(seq_busy), .done_pulse(done_pulse));

  spi_eng_shift #(.HW(HW)) u_shift (
    .clk(clk), .rst_n(rst_n), .half_m1(half_m1), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_byte(tx_byte), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .sclk(spi_sclk), .mosi(spi_mosi), .miso(spi_miso));

  // R1, R7: the serial clock rests low whenever no frame is open
  a_r7_idle_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);
endmodule

// File: tb/tb_spi_cycle_engine.sv
module tb_spi_cycle_engine;
  localparam int CLK_PERIOD = 16;
  localparam int AW = 5;

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, spi_miso = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic spi_cs_n, spi_sclk, spi_mosi;
  int checks = 0, errors = 0;

  spi_cycle_engine dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_cs_n(spi_cs_n),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] menu_op(int i); return 8'(8'h90 + 7*i); endfunction
  function automatic logic [7:0] spat(int p); return 8'(8'h3C + 37*p); endfunction
  function automatic logic [7:0] bp(int i, int j); return 8'(5*j + 16*i + 1); endfunction
  function automatic logic [23:0] op_addr(int i); return 24'(24'hA1B2C3 ^ (i * 24'h010203)); endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); reg_addr = AW'(a); #1 d = reg_rdata;
  endtask

  // flash model: records MOSI frames, returns a position pattern on MISO
  int nfr, bitc, mpos, mbit, hi, hmin, hmax, csh, gap;
  int flen [2];
  logic [7:0] fb [2][80];
  logic [7:0] shin;

  always @(posedge spi_sclk) begin
    shin = {shin[6:0], spi_mosi};
    bitc++;
    if (bitc == 8) begin
      if (nfr < 2) begin
        if (flen[nfr] < 80) fb[nfr][flen[nfr]] = shin;
        flen[nfr]++;
      end
      bitc = 0;
    end
  end
  always @(negedge spi_cs_n) begin
    mpos = 0; mbit = 0; bitc = 0; spi_miso = spat(0)[7];
  end
  always @(negedge spi_sclk) begin
    mbit++;
    if (mbit == 8) begin mbit = 0; mpos++; end
    spi_miso = spat(mpos)[7-mbit];
  end
  always @(posedge spi_cs_n) nfr++;
  always @(negedge clk) begin
    if (spi_sclk) hi++;
    else if (hi > 0) begin
      if (hi < hmin) hmin = hi;
      if (hi > hmax) hmax = hi;
      hi = 0;
    end
    if (spi_cs_n) csh++;
    else begin
      if (csh > 0 && nfr == 1) gap = csh;
      csh = 0;
    end
  end

  task automatic mon_clear();
    nfr = 0; flen[0] = 0; flen[1] = 0; hmin = 1000; hmax = 0; gap = -1; hi = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    do rd(1, s); while (s[0]);
    repeat (2) @(negedge clk);
  endtask

  task automatic run_op(input int i, input bit pre, input bit den, input bit fst, input int cm1);
    logic [31:0] s;
    int typ, nd, half, db, m, bad_w, bad_r;
    bit isw, isa;
    for (int w = 0; w < 16; w++)
      wr(16 + w, {bp(i, 4*w+3), bp(i, 4*w+2), bp(i, 4*w+1), bp(i, 4*w)});
    wr(2, 32'(op_addr(i)));
    mon_clear();
    wr(0, 32'((cm1 << 8) | (i << 4) | (fst << 3) | (den << 2) | (pre << 1) | 1));
    wait_idle();
    typ = i % 4; isw = typ[0]; isa = typ[1];
    nd = den ? cm1 + 1 : 0; half = fst ? 1 : 2; db = isa ? 4 : 1; m = pre ? 1 : 0;
    chk(nfr == (pre ? 2 : 1), "R6 frame count", nfr, pre ? 2 : 1);
    if (pre) begin
      chk(flen[0] == 1 && fb[0][0] == 8'h06, "R6 prefix frame", fb[0][0], 8'h06);
      chk(gap >= 4*half, "R6 chip select gap", gap, 4*half);
    end
    chk(flen[m] == db + nd, den ? "R3 frame length" : "R11 no data phase", flen[m], db + nd);
    chk(fb[m][0] == menu_op(i), "R2 opcode", fb[m][0], menu_op(i));
    if (isa)
      chk({fb[m][1], fb[m][2], fb[m][3]} == op_addr(i), "R3 address bytes",
          {fb[m][1], fb[m][2], fb[m][3]}, op_addr(i));
    if (isw) begin
      bad_w = -1;
      for (int j = 0; j < nd; j++) if (bad_w < 0 && fb[m][db+j] != bp(i, j)) bad_w = j;
      chk(bad_w < 0, "R4 write data", bad_w, -1);
    end
    chk(hmin == half && hmax == half, "R7 sclk high time", hmax, half);
    bad_r = -1;
    for (int w = 0; w < 16; w++) begin
      rd(16 + w, s);
      for (int k = 0; k < 4; k++) begin
        int j = 4*w + k;
        logic [7:0] e = (!isw && j < nd) ? spat(db + j) : bp(i, j);
        if (bad_r < 0 && s[8*k +: 8] != e) bad_r = j;
      end
    end
    chk(bad_r < 0, "R5 buffer contents", bad_r, -1);
    rd(1, s);
    chk(s[2:0] == 3'b010, "R8 done status", s[2:0], 3'b010);
    wr(1, 32'h2);
    rd(1, s);
    chk(s[2:0] == 3'b000, "R8 done cleared", s[2:0], 0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    checks++; errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(1, s); chk(s == 0, "R1 status after reset", s, 0);
    chk(spi_cs_n === 1'b1 && spi_sclk === 1'b0, "R1 idle pins", {spi_cs_n, spi_sclk}, 2'b10);
    rd(3, s); chk(s == 0, "R1 opcode table after reset", s, 0);
    rd(5, s); chk(s == 0, "R1 type table after reset", s, 0);

    wr(3, {menu_op(3), menu_op(2), menu_op(1), menu_op(0)});
    wr(4, {menu_op(7), menu_op(6), menu_op(5), menu_op(4)});
    wr(5, 32'h0000E4E4);
    wr(6, 32'h06);
    rd(4, s); chk(s == {menu_op(7), menu_op(6), menu_op(5), menu_op(4)}, "R2 table readback", s, 0);

    for (int f = 0; f < 2; f++)
      for (int i = 0; i < 8; i++) begin
        bit den = (f == 0) ? (i != 4 && i != 3) : (i != 1 && i != 6);
        run_op(i, bit'((i + f) % 2), den, bit'(f), (i == 7) ? 63 : i*5 + f*2);
      end

    // R9: second launch during a long cycle
    mon_clear();
    wr(0, 32'((63 << 8) | (7 << 4) | (1 << 2) | 1));
    wr(0, 32'((1 << 4) | (1 << 1) | 1));
    rd(1, s); chk(s[2:0] == 3'b101, "R9 busy and error", s[2:0], 3'b101);
    wait_idle();
    chk(nfr == 1 && fb[0][0] == menu_op(7), "R9 cycle unchanged", fb[0][0], menu_op(7));
    chk(flen[0] == 68, "R9 length unchanged", flen[0], 68);
    rd(1, s); chk(s[2:0] == 3'b110, "R9 done and error", s[2:0], 3'b110);
    wr(1, 32'h6);
    rd(1, s); chk(s[2:0] == 3'b000, "R8 both cleared", s[2:0], 0);

    // R10: lock
    wr(7, 32'h1);
    wr(3, 0); wr(4, 0); wr(5, 0); wr(6, 32'h99);
    rd(3, s); chk(s == {menu_op(3), menu_op(2), menu_op(1), menu_op(0)}, "R10 table A frozen", s, 0);
    rd(4, s); chk(s == {menu_op(7), menu_op(6), menu_op(5), menu_op(4)}, "R10 table B frozen", s, 0);
    rd(5, s); chk(s == 32'hE4E4, "R10 types frozen", s, 32'hE4E4);
    rd(6, s); chk(s == 32'h06, "R10 prefix frozen", s, 32'h06);
    run_op(2, 1'b1, 1'b1, 1'b1, 3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule